// File: doc/BRIEF.md
# Counter Timebase Selector with Protected Mode Register

A 16-bit free-running counter whose advance is picked from eight sources by a small mode register. The sources are two free-running prescalers of the system clock (divide by 12 and divide by 4), a timer-0 overflow pulse, falling edges on an external pin, the system clock itself, two slow asynchronous clocks (an external clock and a real-time clock, both already divided by 8) and one reserved code that never counts. The mode register also decides whether counting pauses while the processor idles, enables an interrupt on counter wrap, and holds a watchdog enable bit and a sticky watchdog lock bit.

The register protects itself. While the watchdog enable bit is set, a write to the mode register can do only one thing: clear that bit, provided the lock is not set. Software must clear the watchdog enable before any other field can change. The block provides the watchdog enable output. The compare logic that turns the counter into a watchdog is not part of this block.

The external pin is synchronised by two flops and then handled by a four-state machine. In ST_WAIT_HI the machine waits for a synchronised high level and then moves to ST_ARMED. In ST_ARMED a synchronised low moves it to ST_COUNT, which lasts one cycle and issues one count. ST_COUNT always moves on to ST_HOLD. ST_HOLD lasts a fixed holdoff of two cycles. When it ends, the machine goes to ST_ARMED if the pin is high and to ST_WAIT_HI otherwise. Two counted pin edges are therefore at least four clocks apart.

Top module: `tmr_tbsel`

## Requirements
- R1: After reset the mode read value is 0x40, the counter is 0, the overflow flag and the interrupt are 0, and the watchdog enable output is 1.
- R2: While mode bit 6 (watchdog enable) is 1, a mode write (reg_sel_i=0) leaves bits 7 and 5..0 unchanged. Bit 6 clears only when the written bit 6 is 0 and the lock is clear.
- R3: Mode bit 5 (lock) is sticky: once set it stays set until reset. While it is set, bit 6 cannot be cleared.
- R4: Mode bit 4 always reads 0, whatever value is written.
- R5: Mode bits 3..1 select the timebase. Code 000 gives exactly one count per 12 clocks, 001 one count per 4 clocks, 100 one count per clock, and 111 no counts.
- R6: With code 010 the counter advances once for each clock cycle in which t0_ovf_i is high.
- R7: With code 011 each falling edge on pin_i, after a two-flop synchronizer, adds one count. Edges spaced 8 clocks apart are all counted. At most one count is made in any 4 consecutive clocks.
- R8: With code 101 each rising edge of xclk_slow_i adds one count, and with code 110 each rising edge of rtc_slow_i adds one count. Both inputs are synchronised first, and the other slow input is ignored.
- R9: When mode bit 7 is 1 and idle_i is 1, the counter holds its value. When bit 7 is 0, idle_i has no effect.
- R10: The overflow flag sets when the counter advances from 0xFFFF to 0x0000. A flag write (reg_sel_i=1) with data bit 0 equal to 0 clears it, and data bit 0 equal to 1 has no effect. A wrap in the same cycle wins over a clear.
- R11: irq_o is 1 exactly when the overflow flag is 1 and mode bit 0 is 1.
- R12: wdog_en_o equals mode bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idle_i | input | 1 | Processor idle indication |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 selects the mode register, 1 selects the flag |
| reg_wdata_i | input | 8 | Write data |
| mode_o | output | 8 | Mode register read value |
| t0_ovf_i | input | 1 | Timer-0 overflow pulse |
| pin_i | input | 1 | External count pin, asynchronous |
| xclk_slow_i | input | 1 | External clock divided by 8, asynchronous |
| rtc_slow_i | input | 1 | Real-time clock divided by 8, asynchronous |
| count_o | output | 16 | Counter value |
| ovf_flag_o | output | 1 | Overflow flag |
| irq_o | output | 1 | Interrupt request |
| wdog_en_o | output | 1 | Watchdog enable |

## Verification
Some properties are checked on every cycle. The write protection and the sticky lock must hold. The counter must stay frozen while an idle pause applies or while the reserved code is selected. The overflow flag must set on a wrap and stay set until cleared, and counted pin pulses must never come closer than four cycles apart. Other behaviours can only be shown by the bench's scenarios: the exact count rate over a window for each timebase, the delays through the synchronizers, that every well-spaced pin edge is counted, that the unselected slow clock is ignored, and how flag and interrupt interact across a real wrap of the counter.

// File: rtl/tmr_tbsel_pkg.sv
package tmr_tbsel_pkg;

    typedef enum logic [2:0] {
        SEL_DIV12 = 3'd0,
        SEL_DIV4  = 3'd1,
        SEL_T0    = 3'd2,
        SEL_PIN   = 3'd3,
        SEL_SYS   = 3'd4,
        SEL_XCLK  = 3'd5,
        SEL_RTC   = 3'd6,
        SEL_NONE  = 3'd7
    } tbase_e;

    // Field order is fixed by the register's bit positions (7 down to 0).
    typedef struct packed {
        logic   idle_hold;
        logic   wd_en;
        logic   wd_lock;
        logic   spare;
        tbase_e sel;
        logic   irq_en;
    } mode_t;

    localparam mode_t MODE_RESET = 8'h40;

    typedef enum logic [1:0] {
        ST_WAIT_HI = 2'd0,
        ST_ARMED   = 2'd1,
        ST_COUNT   = 2'd2,
        ST_HOLD    = 2'd3
    } pin_st_e;

endpackage

// File: rtl/tmr_div.sv
module tmr_div #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

    logic [W-1:0] cnt;

    assign tick_o = (cnt == W'(DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (tick_o) cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/tmr_slow_sync.sv
module tmr_slow_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic s1, s2, s3;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= async_i;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign rise_o = s2 & ~s3;
endmodule

// File: rtl/tmr_pin_edge.sv
module tmr_pin_edge
    import tmr_tbsel_pkg::*;
#(
    parameter int HOLD_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic pulse_o
);
    localparam int HW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;

    logic    s1, s2;
    pin_st_e state, state_nx;
    logic [HW-1:0] hcnt, hcnt_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
        end else begin
            s1 <= pin_i;
            s2 <= s1;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_WAIT_HI;
            hcnt  <= '0;
        end else begin
            state <= state_nx;
            hcnt  <= hcnt_nx;
        end
    end

    // Next state
    always_comb begin
        state_nx = state;
        hcnt_nx  = hcnt;
        unique case (state)
            ST_WAIT_HI: if (s2)  state_nx = ST_ARMED;
            ST_ARMED:   if (!s2) state_nx = ST_COUNT;
            ST_COUNT: begin
                state_nx = ST_HOLD;
                hcnt_nx  = HW'(HOLD_CYC - 1);
            end
            ST_HOLD: begin
                if (hcnt == '0) state_nx = s2 ? ST_ARMED : ST_WAIT_HI;
                else            hcnt_nx  = hcnt - 1'b1;
            end
        endcase
    end

    // Outputs
    always_comb begin
        pulse_o = (state == ST_COUNT);
    end

    AST_PIN_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o ##1 !pulse_o ##1 !pulse_o); // R7
endmodule

// File: rtl/tmr_mode_reg.sv
module tmr_mode_reg
    import tmr_tbsel_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_i,
    input  logic [7:0] wdata_i,
    output mode_t      mode_o
);
    mode_t mode;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode <= MODE_RESET;
        end else if (wr_i) begin
            if (mode.wd_en) begin
                if (!wdata_i[6] && !mode.wd_lock) mode.wd_en <= 1'b0;
            end else begin
                mode.idle_hold <= wdata_i[7];
                mode.wd_en     <= wdata_i[6];
                mode.wd_lock   <= mode.wd_lock | wdata_i[5];
                mode.spare     <= 1'b0;
                mode.sel       <= tbase_e'(wdata_i[3:1]);
                mode.irq_en    <= wdata_i[0];
            end
        end
    end

    assign mode_o = mode;

    AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && mode.wd_en) |=> ({mode[7], mode[5:0]} == $past({mode[7], mode[5:0]}))); // R2
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        mode.wd_lock |=> mode.wd_lock); // R3
    AST_LOCK_KEEPS_WD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode.wd_lock && mode.wd_en) |=> mode.wd_en); // R3
endmodule

// File: rtl/tmr_tbsel.sv
module tmr_tbsel
    import tmr_tbsel_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int DIV_SLOW = 12,
    parameter int DIV_FAST = 4,
    parameter int PIN_HOLD = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idle_i,
    input  logic             reg_wr_i,
    input  logic             reg_sel_i,
    input  logic [7:0]       reg_wdata_i,
    output logic [7:0]       mode_o,
    input  logic             t0_ovf_i,
    input  logic             pin_i,
    input  logic             xclk_slow_i,
    input  logic             rtc_slow_i,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_flag_o,
    output logic             irq_o,
    output logic             wdog_en_o
);
    localparam int NPRE  = 2;
    localparam int NSLOW = 2;

    mode_t            mode;
    logic [NPRE-1:0]  pre_tick;
    logic [NSLOW-1:0] slow_tick;
    logic [NSLOW-1:0] slow_in;
    logic             pin_tick;
    logic             tick, adv, flag_clr;
    logic [CNT_W-1:0] count;
    logic             flag;

    assign slow_in = {rtc_slow_i, xclk_slow_i};

    genvar g;
    generate
        for (g = 0; g < NPRE; g++) begin : g_pre
            tmr_div #(.DIV((g == 0) ? DIV_SLOW : DIV_FAST)) u_div (
                .clk(clk), .rst_n(rst_n), .tick_o(pre_tick[g]));
        end
        for (g = 0; g < NSLOW; g++) begin : g_slow
            tmr_slow_sync u_sync (
                .clk(clk), .rst_n(rst_n), .async_i(slow_in[g]), .rise_o(slow_tick[g]));
        end
    endgenerate

    tmr_pin_edge #(.HOLD_CYC(PIN_HOLD)) u_pin (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .pulse_o(pin_tick));

    tmr_mode_reg u_mode (
        .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i && !reg_sel_i),
        .wdata_i(reg_wdata_i), .mode_o(mode));

    always_comb begin
        unique case (mode.sel)
            SEL_DIV12: tick = pre_tick[0];
            SEL_DIV4:  tick = pre_tick[1];
            SEL_T0:    tick = t0_ovf_i;
            SEL_PIN:   tick = pin_tick;
            SEL_SYS:   tick = 1'b1;
            SEL_XCLK:  tick = slow_tick[0];
            SEL_RTC:   tick = slow_tick[1];
            SEL_NONE:  tick = 1'b0;
        endcase
    end

    assign adv      = tick && !(mode.idle_hold && idle_i);
    assign flag_clr = reg_wr_i && reg_sel_i && !reg_wdata_i[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
            flag  <= 1'b0;
        end else begin
            if (adv) count <= count + 1'b1;
            if (adv && (count == '1)) flag <= 1'b1;
            else if (flag_clr)        flag <= 1'b0;
        end
    end

    assign mode_o     = mode;
    assign count_o    = count;
    assign ovf_flag_o = flag;
    assign irq_o      = flag && mode.irq_en;
    assign wdog_en_o  = mode.wd_en;

    AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode.idle_hold && idle_i) |=> (count == $past(count))); // R9
    AST_RSV_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode.sel == SEL_NONE) |=> (count == $past(count))); // R5
    AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && (count == '1)) |=> (flag && (count == '0))); // R10
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> flag); // R10
    AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_i |=> (mode_o[4] == 1'b0)); // R4
endmodule

// File: tb/sim_tmr_tbsel.sv
`timescale 1ns/1ps
module sim_tmr_tbsel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        idle_i = 1'b0;
    logic        reg_wr_i = 1'b0;
    logic        reg_sel_i = 1'b0;
    logic [7:0]  reg_wdata_i = 8'h00;
    logic [7:0]  mode_o;
    logic        t0_ovf_i = 1'b0;
    logic        pin_i = 1'b1;
    logic        xclk_slow_i = 1'b0;
    logic        rtc_slow_i = 1'b0;
    logic [15:0] count_o;
    logic        ovf_flag_o, irq_o, wdog_en_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tmr_tbsel u0 (
        .clk(clk), .rst_n(rst_n), .idle_i(idle_i), .reg_wr_i(reg_wr_i),
        .reg_sel_i(reg_sel_i), .reg_wdata_i(reg_wdata_i), .mode_o(mode_o),
        .t0_ovf_i(t0_ovf_i), .pin_i(pin_i), .xclk_slow_i(xclk_slow_i),
        .rtc_slow_i(rtc_slow_i), .count_o(count_o), .ovf_flag_o(ovf_flag_o),
        .irq_o(irq_o), .wdog_en_o(wdog_en_o));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Expected mode value after a write, from R2, R3, R4
    function automatic logic [7:0] exp_mode(input logic [7:0] cur, input logic [7:0] d);
        logic [7:0] r;
        r = cur;
        if (cur[6]) begin
            if (!d[6] && !cur[5]) r[6] = 1'b0;
        end else begin
            r = d & 8'hEF;
            r[5] = cur[5] | d[5];
        end
        return r;
    endfunction

    // Counts expected in a window for the clock-derived timebases, from R5
    function automatic int exp_rate(input logic [2:0] sel, input int cyc);
        case (sel)
            3'd0:    return cyc / 12;
            3'd1:    return cyc / 4;
            3'd4:    return cyc;
            default: return 0;
        endcase
    endfunction

    task automatic wr(input logic sel, input logic [7:0] d);
        reg_sel_i   = sel;
        reg_wdata_i = d;
        reg_wr_i    = 1'b1;
        @(negedge clk);
        reg_wr_i    = 1'b0;
    endtask

    task automatic window(input int cyc, output int delta);
        logic [15:0] a;
        a = count_o;
        repeat (cyc) @(negedge clk);
        delta = int'(count_o - a);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(negedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int d;
        logic [7:0] m, v;
        void'($urandom(32'd2024));
        do_reset();

        // R1 reset state, R12
        check(mode_o == 8'h40, "R1 mode", mode_o, 8'h40);
        check(ovf_flag_o == 1'b0 && irq_o == 1'b0, "R1 flag/irq", {ovf_flag_o, irq_o}, 0);
        check(wdog_en_o == 1'b1, "R12 wdog_en at reset", wdog_en_o, 1);

        // R2 protected writes
        wr(1'b0, 8'h48);
        check(mode_o == 8'h40, "R2 write ignored", mode_o, 8'h40);
        wr(1'b0, 8'h7F);
        check(mode_o == 8'h40, "R2 write with bit6 set ignored", mode_o, 8'h40);
        window(120, d);
        check(d == 10, "R5 div12 while protected", d, 10);
        wr(1'b0, 8'h3E);
        check(mode_o == 8'h00, "R2 clear of watchdog enable", mode_o, 8'h00);
        check(wdog_en_o == 1'b0, "R12 wdog_en follows bit6", wdog_en_o, 0);

        // R4 and random writes with watchdog off
        m = 8'h00;
        for (int i = 0; i < 20; i++) begin
            v = 8'($urandom) & 8'h9F;
            wr(1'b0, v);
            m = exp_mode(m, v);
            check(mode_o == m, "R4 random mode write", mode_o, m);
        end

        // R5 timebases, directed and random
        wr(1'b0, 8'h00); window(120, d); check(d == exp_rate(3'd0, 120), "R5 div12", d, 10);
        wr(1'b0, 8'h02); window(120, d); check(d == exp_rate(3'd1, 120), "R5 div4", d, 30);
        wr(1'b0, 8'h08); window(120, d); check(d == exp_rate(3'd4, 120), "R5 sysclk", d, 120);
        wr(1'b0, 8'h0E); window(120, d); check(d == 0, "R5 reserved", d, 0);
        for (int i = 0; i < 8; i++) begin
            logic [2:0] s;
            int n;
            case ($urandom % 4)
                0: s = 3'd0;
                1: s = 3'd1;
                2: s = 3'd4;
                default: s = 3'd7;
            endcase
            n = 12 * (1 + int'($urandom % 10));
            wr(1'b0, {4'b0000, s, 1'b0});
            window(n, d);
            check(d == exp_rate(s, n), "R5 random timebase", d, exp_rate(s, n));
        end

        // R6 timer-0 overflow pulses
        wr(1'b0, 8'h04);
        begin
            logic [15:0] a;
            int k;
            a = count_o;
            k = 0;
            for (int i = 0; i < 30; i++) begin
                t0_ovf_i = ($urandom % 3) == 0;
                if (t0_ovf_i) k++;
                @(negedge clk);
            end
            t0_ovf_i = 1'b0;
            @(negedge clk);
            check(int'(count_o - a) == k, "R6 timer-0 pulses", int'(count_o - a), k);
        end

        // R7 pin falling edges
        wr(1'b0, 8'h06);
        repeat (6) @(negedge clk);
        begin
            logic [15:0] a;
            a = count_o;
            for (int i = 0; i < 6; i++) begin
                pin_i = 1'b0; repeat (4) @(negedge clk);
                pin_i = 1'b1; repeat (4) @(negedge clk);
            end
            repeat (6) @(negedge clk);
            check(count_o - a == 16'd6, "R7 spaced pin edges", int'(count_o - a), 6);
            a = count_o;
            for (int i = 0; i < 40; i++) begin
                pin_i = ~pin_i;
                @(negedge clk);
            end
            pin_i = 1'b1;
            repeat (8) @(negedge clk);
            check(int'(count_o - a) <= 11 && int'(count_o - a) >= 1,
                  "R7 fast pin rate limit", int'(count_o - a), 10);
        end

        // R8 slow clocks
        wr(1'b0, 8'h0A);
        repeat (4) @(negedge clk);
        begin
            logic [15:0] a;
            a = count_o;
            for (int i = 0; i < 5; i++) begin
                xclk_slow_i = 1'b1; rtc_slow_i = 1'b1; repeat (8) @(negedge clk);
                xclk_slow_i = 1'b0; rtc_slow_i = 1'b0; repeat (8) @(negedge clk);
            end
            repeat (4) @(negedge clk);
            check(count_o - a == 16'd5, "R8 external slow clock", int'(count_o - a), 5);
            wr(1'b0, 8'h0C);
            repeat (4) @(negedge clk);
            a = count_o;
            for (int i = 0; i < 3; i++) begin
                xclk_slow_i = 1'b1; repeat (8) @(negedge clk);
                xclk_slow_i = 1'b0; repeat (8) @(negedge clk);
            end
            check(count_o == a, "R8 other slow clock ignored", count_o, a);
            for (int i = 0; i < 4; i++) begin
                rtc_slow_i = 1'b1; repeat (8) @(negedge clk);
                rtc_slow_i = 1'b0; repeat (8) @(negedge clk);
            end
            repeat (4) @(negedge clk);
            check(count_o - a == 16'd4, "R8 real-time slow clock", int'(count_o - a), 4);
        end

        // R9 idle control
        wr(1'b0, 8'h88);
        idle_i = 1'b1; window(50, d); idle_i = 1'b0;
        check(d == 0, "R9 idle hold", d, 0);
        window(50, d);
        check(d == 50, "R9 runs when not idle", d, 50);
        wr(1'b0, 8'h08);
        idle_i = 1'b1; window(50, d); idle_i = 1'b0;
        check(d == 50, "R9 idle ignored when bit7 clear", d, 50);

        // R10 / R11 overflow
        wr(1'b0, 8'h09);
        begin
            int guard = 0;
            while (count_o != 16'hFFFF && guard < 70000) begin
                @(negedge clk);
                guard++;
            end
        end
        check(ovf_flag_o == 1'b0, "R10 flag clear before wrap", ovf_flag_o, 0);
        @(negedge clk);
        check(ovf_flag_o == 1'b1 && count_o == 16'h0000, "R10 flag on wrap",
              {ovf_flag_o, count_o}, 17'h10000);
        check(irq_o == 1'b1, "R11 irq with enable", irq_o, 1);
        wr(1'b0, 8'h08);
        check(irq_o == 1'b0 && ovf_flag_o == 1'b1, "R11 irq masked", {irq_o, ovf_flag_o}, 1);
        wr(1'b1, 8'h01);
        check(ovf_flag_o == 1'b1, "R10 write of 1 ignored", ovf_flag_o, 1);
        wr(1'b1, 8'h00);
        check(ovf_flag_o == 1'b0, "R10 flag cleared", ovf_flag_o, 0);

        // R3 lock
        wr(1'b0, 8'hFF);
        check(mode_o == 8'hEF, "R3 lock set", mode_o, 8'hEF);
        wr(1'b0, 8'h00);
        check(mode_o == 8'hEF && wdog_en_o, "R3 locked enable kept", mode_o, 8'hEF);
        do_reset();
        check(mode_o == 8'h40, "R3 lock cleared by reset", mode_o, 8'h40);
        wr(1'b0, 8'h00);
        check(mode_o == 8'h00, "R3 unlocked clear after reset", mode_o, 8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule